// File: doc/BRIEF.md
# Shift-Add Multiplier Datapath

This block is the register and arithmetic half of an unsigned sequential multiplier of parameterised width `WIDTH` (default 8). It holds four pieces of state: a multiplicand register, a multiplier register, a partial-product accumulator and a carry flip-flop. It also holds an iteration down-counter, an adder that sums the accumulator and the multiplicand, and a zero detector on the counter. An external sequencer drives it with single-cycle strobes and reads back two status bits.

A run goes like this. The operands are brought in with the operand strobe. The initialise strobe then clears the accumulator and the carry and presets the counter. After that, the sequencer alternates two steps:

- an add step, issued only when the multiplier's low bit is 1;
- a shift step, which also decrements the counter.

The sequencer stops once the zero flag is seen high during a shift step. The double-width product is then the accumulator concatenated with the multiplier register.

The adder is built either from the plain `+` operator or as an explicit ripple-carry chain, selected by a parameter.

Top module: `shiftadd_mul_dp`

## Requirements
- R1: After reset, every register and the counter are zero: `product_o` is 0, `q_lsb_o` is 0 and `zero_o` is 1.
- R2: A cycle with `opnd_ld_i` high loads `mcand_i` into the multiplicand register and `mplier_i` into the multiplier register, which appears as `product_o[WIDTH-1:0]` after that edge.
- R3: A cycle with `init_i` high clears the accumulator (`product_o[2*WIDTH-1:WIDTH]`) and the carry, and presets the counter to `WIDTH-1`, so `zero_o` reads 0 afterwards.
- R4: A cycle with `acc_ld_i` high (and `init_i` low) writes the low `WIDTH` bits of accumulator plus multiplicand into the accumulator, and writes the adder carry-out into the carry flip-flop.
- R5: A cycle with `shift_dec_i` high (and `init_i` and `acc_ld_i` low) shifts the chain {carry, accumulator, multiplier} right by one bit. The carry becomes the accumulator MSB, the old accumulator LSB becomes the multiplier MSB, the carry becomes 0, and the counter decrements by one.
- R6: A cycle with `clr_c_i` high clears the carry flip-flop and nothing else. This takes precedence over an add's carry-out.
- R7: `zero_o` is 1 exactly when the counter is 0. Decrementing a counter at 0 wraps it to all ones.
- R8: `q_lsb_o` is bit 0 of the multiplier register.
- R9: Load, initialise, then `WIDTH` rounds of (add if `q_lsb_o`, then shift) leaves `product_o` equal to the unsigned product. `zero_o` is 1 only before the last shift.
- R10: Strobe precedence is init over add over shift for the accumulator, the counter and the multiplier shift. The operand strobe overrides a shift on the multiplier register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| opnd_ld_i | input | 1 | Load both operands |
| mcand_i | input | WIDTH | Multiplicand operand |
| mplier_i | input | WIDTH | Multiplier operand |
| init_i | input | 1 | Clear accumulator and carry, preset counter |
| acc_ld_i | input | 1 | Accumulator gets accumulator plus multiplicand |
| clr_c_i | input | 1 | Clear carry flip-flop |
| shift_dec_i | input | 1 | Shift chain right, decrement counter |
| zero_o | output | 1 | Counter equals zero |
| q_lsb_o | output | 1 | Multiplier register bit 0 |
| product_o | output | 2*WIDTH | Accumulator and multiplier register concatenated |

## Verification
The carry flip-flop has no port of its own, so its effects are hard to observe. That covers both the adder carry landing in it and a separate clear removing it. The stimulus first adds an all-ones multiplicand twice to force a carry-out. It then either issues the clear or does not, and follows with a shift. The carry's value then shows up as the accumulator MSB at `product_o`. Counter wrap and strobe collisions are reached the same way: directed strobe patterns that no well-behaved sequencer would issue.

// File: rtl/mdp_pkg.sv
package mdp_pkg;
   localparam int ADD_OPERATOR = 0;
   localparam int ADD_RIPPLE   = 1;

   function automatic int cnt_bits(input int w);
      return (w < 3) ? 1 : $clog2(w);
   endfunction
endpackage

// File: rtl/mdp_adder.sv
module mdp_adder #(
   parameter int WIDTH = 8,
   parameter int KIND  = mdp_pkg::ADD_OPERATOR
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             cout_o
);
   if (WIDTH < 1) begin : g_bad_width
      $error("mdp_adder: WIDTH must be positive");
   end
   if (KIND != mdp_pkg::ADD_OPERATOR && KIND != mdp_pkg::ADD_RIPPLE) begin : g_bad_kind
      $error("mdp_adder: unknown KIND");
   end

   if (KIND == mdp_pkg::ADD_RIPPLE) begin : g_ripple
      logic [WIDTH:0] cy;
      assign cy[0] = 1'b0;
      for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
         assign sum_o[gi]  = a_i[gi] ^ b_i[gi] ^ cy[gi];
         assign cy[gi+1]   = (a_i[gi] & b_i[gi]) | (cy[gi] & (a_i[gi] ^ b_i[gi]));
      end
      assign cout_o = cy[WIDTH];

      // chain result compared with arithmetic sum
      always_comb begin
         if (!$isunknown({a_i, b_i})) begin
            AST_RIPPLE_SUM: assert ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i}))
               else $error("ripple adder mismatch"); // R4
         end
      end
   end else begin : g_operator
      logic [WIDTH:0] full;
      assign full   = {1'b0, a_i} + {1'b0, b_i};
      assign sum_o  = full[WIDTH-1:0];
      assign cout_o = full[WIDTH];
   end
endmodule

// File: rtl/mdp_counter.sv
module mdp_counter #(
   parameter int WIDTH = 8,
   localparam int PW   = mdp_pkg::cnt_bits(WIDTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          preset_i,
   input  logic          dec_i,
   output logic [PW-1:0] cnt_o,
   output logic          zero_o
);
   localparam logic [PW-1:0] PRESET_VAL = PW'(WIDTH - 1);

   if ((WIDTH - 1) >= (1 << PW)) begin : g_bad_pw
      $error("mdp_counter: counter too narrow for WIDTH-1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_o <= '0;
      end else if (preset_i) begin
         cnt_o <= PRESET_VAL;
      end else if (dec_i) begin
         cnt_o <= cnt_o - PW'(1);
      end
   end

   assign zero_o = (cnt_o == '0);

   AST_PRESET_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      preset_i |=> (cnt_o == PRESET_VAL) && !zero_o) else $error("preset"); // R3
   AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_i && !preset_i) |=> cnt_o == $past(cnt_o) - PW'(1)) else $error("dec"); // R5
   AST_ZERO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_i && !preset_i && zero_o) |=> (cnt_o == '1)) else $error("wrap"); // R7
   AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!dec_i && !preset_i) |=> $stable(cnt_o)) else $error("hold"); // R7
endmodule

// File: rtl/mdp_regs.sv
module mdp_regs #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             opnd_ld_i,
   input  logic [WIDTH-1:0] mcand_i,
   input  logic [WIDTH-1:0] mplier_i,
   input  logic             init_i,
   input  logic             add_i,
   input  logic             clr_c_i,
   input  logic             shift_i,
   input  logic [WIDTH-1:0] sum_i,
   input  logic             cout_i,
   output logic [WIDTH-1:0] acc_o,
   output logic [WIDTH-1:0] mcand_o,
   output logic [WIDTH-1:0] mplier_o,
   output logic             carry_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mcand_o <= '0;
      end else if (opnd_ld_i) begin
         mcand_o <= mcand_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_o <= '0;
      end else if (init_i) begin
         acc_o <= '0;
      end else if (add_i) begin
         acc_o <= sum_i;
      end else if (shift_i) begin
         acc_o <= {carry_o, acc_o[WIDTH-1:1]};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         carry_o <= 1'b0;
      end else if (init_i || clr_c_i) begin
         carry_o <= 1'b0;
      end else if (add_i) begin
         carry_o <= cout_i;
      end else if (shift_i) begin
         carry_o <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mplier_o <= '0;
      end else if (opnd_ld_i) begin
         mplier_o <= mplier_i;
      end else if (shift_i) begin
         mplier_o <= {acc_o[0], mplier_o[WIDTH-1:1]};
      end
   end

   AST_OPND_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      opnd_ld_i |=> (mcand_o == $past(mcand_i)) && (mplier_o == $past(mplier_i)))
      else $error("operand load"); // R2
   AST_INIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      init_i |=> (acc_o == '0) && !carry_o) else $error("init"); // R3
   AST_ADD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      (add_i && !clr_c_i) |=> {carry_o, acc_o} == ({1'b0, $past(acc_o)} + {1'b0, $past(mcand_o)}))
      else $error("add"); // R4
   AST_SHIFT_ACC: assert property (@(posedge clk) disable iff (!rst_n)
      shift_i |=> (acc_o == {$past(carry_o), $past(acc_o[WIDTH-1:1])}) && !carry_o)
      else $error("shift acc"); // R5
   AST_SHIFT_MPLIER: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_i && !opnd_ld_i) |=> mplier_o == {$past(acc_o[0]), $past(mplier_o[WIDTH-1:1])})
      else $error("shift mplier"); // R5
   AST_CLR_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      clr_c_i |=> !carry_o) else $error("clr carry"); // R6
   AST_CLR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_c_i && !init_i && !add_i && !shift_i && !opnd_ld_i) |=> $stable(acc_o) && $stable(mplier_o))
      else $error("clr side effect"); // R6
endmodule

// File: rtl/shiftadd_mul_dp.sv
module shiftadd_mul_dp #(
   parameter int WIDTH      = 8,
   parameter int ADDER_KIND = mdp_pkg::ADD_OPERATOR
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 opnd_ld_i,
   input  logic [WIDTH-1:0]     mcand_i,
   input  logic [WIDTH-1:0]     mplier_i,
   input  logic                 init_i,
   input  logic                 acc_ld_i,
   input  logic                 clr_c_i,
   input  logic                 shift_dec_i,
   output logic                 zero_o,
   output logic                 q_lsb_o,
   output logic [2*WIDTH-1:0]   product_o
);
   localparam int PW = mdp_pkg::cnt_bits(WIDTH);

   if (WIDTH < 2) begin : g_bad_width
      $error("shiftadd_mul_dp: WIDTH must be at least 2");
   end

   logic             do_add;
   logic             do_shift;
   logic [WIDTH-1:0] acc;
   logic [WIDTH-1:0] mcand;
   logic [WIDTH-1:0] mplier;
   logic             carry;
   logic [WIDTH-1:0] sum;
   logic             cout;
   logic [PW-1:0]    cnt;

   // precedence: init, then add, then shift
   assign do_add   = acc_ld_i & ~init_i;
   assign do_shift = shift_dec_i & ~init_i & ~acc_ld_i;

   mdp_adder #(.WIDTH(WIDTH), .KIND(ADDER_KIND)) u_adder (
      .a_i    (acc),
      .b_i    (mcand),
      .sum_o  (sum),
      .cout_o (cout)
   );

   mdp_regs #(.WIDTH(WIDTH)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .opnd_ld_i (opnd_ld_i),
      .mcand_i   (mcand_i),
      .mplier_i  (mplier_i),
      .init_i    (init_i),
      .add_i     (do_add),
      .clr_c_i   (clr_c_i),
      .shift_i   (do_shift),
      .sum_i     (sum),
      .cout_i    (cout),
      .acc_o     (acc),
      .mcand_o   (mcand),
      .mplier_o  (mplier),
      .carry_o   (carry)
   );

   mdp_counter #(.WIDTH(WIDTH)) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .preset_i (init_i),
      .dec_i    (do_shift),
      .cnt_o    (cnt),
      .zero_o   (zero_o)
   );

   assign q_lsb_o   = mplier[0];
   assign product_o = {acc, mplier};

   AST_INIT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (init_i && !opnd_ld_i) |=> (product_o[WIDTH-1:0] == $past(product_o[WIDTH-1:0])))
      else $error("init precedence"); // R10
   AST_ADD_BLOCKS_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_ld_i && !init_i && !opnd_ld_i) |=> $stable(mplier) && $stable(cnt))
      else $error("add precedence"); // R10
   AST_CARRY_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(carry) |-> $past(do_add)) else $error("carry source"); // R4
endmodule

// File: tb/shiftadd_mul_dp_tb_top.sv
module shiftadd_mul_dp_tb_top;
   localparam int W = 8;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           opnd_ld = 1'b0;
   logic [W-1:0]   mcand = '0;
   logic [W-1:0]   mplier = '0;
   logic           init = 1'b0;
   logic           acc_ld = 1'b0;
   logic           clr_c = 1'b0;
   logic           shift_dec = 1'b0;
   logic           zero;
   logic           q_lsb;
   logic [2*W-1:0] product;

   int checks = 0;
   int failures = 0;

   always #5 clk = ~clk;

   shiftadd_mul_dp #(.WIDTH(W)) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .opnd_ld_i   (opnd_ld),
      .mcand_i     (mcand),
      .mplier_i    (mplier),
      .init_i      (init),
      .acc_ld_i    (acc_ld),
      .clr_c_i     (clr_c),
      .shift_dec_i (shift_dec),
      .zero_o      (zero),
      .q_lsb_o     (q_lsb),
      .product_o   (product)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // drive strobes for one edge; returns at the following falling edge
   task automatic pulse(input logic ld, input logic in, input logic ac,
                        input logic cl, input logic sh);
      opnd_ld = ld; init = in; acc_ld = ac; clr_c = cl; shift_dec = sh;
      @(negedge clk);
      opnd_ld = 0; init = 0; acc_ld = 0; clr_c = 0; shift_dec = 0;
   endtask

   task automatic load_ops(input logic [W-1:0] b, input logic [W-1:0] q);
      mcand = b; mplier = q;
      pulse(1, 0, 0, 0, 0);
   endtask

   task automatic t_reset();
      check("R1 product", 32'(product), 0);
      check("R1 zero", 32'(zero), 1);
      check("R1 q_lsb", 32'(q_lsb), 0);
   endtask

   task automatic t_operands();
      load_ops(8'hA5, 8'h3C);
      check("R2 product", 32'(product), 32'h003C);
      check("R8 q_lsb low", 32'(q_lsb), 0);
      load_ops(8'hA5, 8'h81);
      check("R8 q_lsb high", 32'(q_lsb), 1);
      pulse(0, 0, 1, 0, 0);
      check("R4 add A", 32'(product), 32'hA581);
      pulse(0, 1, 0, 0, 0);
      check("R3 clear A", 32'(product), 32'h0081);
      check("R3 zero low", 32'(zero), 0);
   endtask

   task automatic t_carry();
      load_ops(8'hFF, 8'h00);
      pulse(0, 1, 0, 0, 0);
      pulse(0, 0, 1, 0, 0);
      pulse(0, 0, 1, 0, 0);
      check("R4 wrapped sum", 32'(product), 32'hFE00);
      pulse(0, 0, 0, 0, 1);
      check("R5 carry into msb", 32'(product), 32'hFF00);
      pulse(0, 0, 0, 0, 1);
      check("R5 carry cleared by shift", 32'(product), 32'h7F80);
   endtask

   task automatic t_clr_c();
      load_ops(8'hFF, 8'h00);
      pulse(0, 1, 0, 0, 0);
      pulse(0, 0, 1, 0, 0);
      pulse(0, 0, 1, 0, 0);
      pulse(0, 0, 0, 1, 0);
      check("R6 A untouched", 32'(product), 32'hFE00);
      pulse(0, 0, 0, 0, 1);
      check("R6 carry gone", 32'(product), 32'h7F00);
   endtask

   task automatic t_counter();
      pulse(0, 1, 0, 0, 0);
      for (int i = 0; i < W - 1; i++) begin
         check("R7 zero before end", 32'(zero), 0);
         pulse(0, 0, 0, 0, 1);
      end
      check("R7 zero at end", 32'(zero), 1);
      pulse(0, 0, 0, 0, 1);
      check("R7 wrap", 32'(zero), 0);
   endtask

   task automatic t_priority();
      load_ops(8'h01, 8'hF0);
      pulse(0, 1, 0, 0, 0);
      pulse(0, 0, 1, 0, 0);
      check("R10 setup", 32'(product), 32'h01F0);
      pulse(0, 1, 1, 0, 1);
      check("R10 init wins", 32'(product), 32'h00F0);
      pulse(0, 0, 1, 0, 1);
      check("R10 add beats shift", 32'(product), 32'h01F0);
      for (int i = 0; i < W - 1; i++) pulse(0, 0, 0, 0, 1);
      check("R10 no decrement on collision", 32'(zero), 1);
      mplier = 8'h55;
      opnd_ld = 1;
      pulse(1, 0, 0, 0, 1);
      check("R10 load beats shift", 32'(product[W-1:0]), 32'h55);
   endtask

   task automatic t_multiply(input logic [W-1:0] b, input logic [W-1:0] q);
      load_ops(b, q);
      pulse(0, 1, 0, 1, 0);
      for (int i = 0; i < W; i++) begin
         if (q_lsb) pulse(0, 0, 1, 0, 0);
         if (zero !== (i == W - 1)) begin
            check("R9 zero timing", 32'(zero), 32'(i == W - 1));
         end
         pulse(0, 0, 0, 1, 1);
      end
      check("R9 product", 32'(product), 32'(b) * 32'(q));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_operands();
      t_carry();
      t_clr_c();
      t_counter();
      t_priority();
      t_multiply(8'd0, 8'd0);
      t_multiply(8'd255, 8'd255);
      t_multiply(8'd13, 8'd11);
      t_multiply(8'd128, 8'd2);
      t_multiply(8'd1, 8'd255);
      t_multiply(8'd200, 8'd170);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule